// File: doc/BRIEF.md
# Four-Channel DMA Host Register File

This block is the software-visible register file of a four-channel DMA controller. A host reaches every register through an 8-bit I/O port with a 4-bit offset. Each channel has a 16-bit transfer address and a 16-bit word count, and each is held as a base copy and a current copy. Each channel also has a 6-bit mode field and a mask bit. A command byte, a status byte and one shared byte-order toggle complete the set. The toggle lets the 8-bit port reach the low and then the high byte of any 16-bit register.

A separate transfer sequencer reads the programmed values from the output buses. It writes back the running address and count into the current copies, and it raises terminal-count pulses that latch into the status byte. The host selects a channel for a mask or mode write with the two low data bits. Reads return data one cycle after the read strobe.

Top module: `dma_host_regs`

## Requirements
- R1: A synchronous reset sets all four mask bits to 1 and the byte toggle to the low state. It clears every address, count, mode, command and terminal-count register, and it clears `io_rdata`.
- R2: A write to offset 2n loads channel n's address, and a write to offset 2n+1 loads its count (n = 0..3). The byte chosen by the toggle goes into both the base copy and the current copy.
- R3: Every read or write at offsets 0x0 to 0x7 flips the single byte toggle, whatever the channel. The low byte [7:0] is used when the toggle is clear and the high byte [15:8] when it is set.
- R4: Any write to offset 0xC returns the toggle to the low state.
- R5: A read at offsets 0x0 to 0x7 returns the toggle-selected byte of the channel's current copy on `io_rdata` in the cycle after the strobe. A cycle with no read leaves `io_rdata` at 0.
- R6: A write to offset 0xA applies to the channel in data[1:0]. It sets that channel's mask when data[2]=1 and clears it when data[2]=0.
- R7: A write to offset 0xB stores data[7:2] as the mode of the channel in data[1:0]. For example, 0x44 gives 0x11, 0x48 gives 0x12 and 0xC0 gives 0x30.
- R8: A write to offset 0xE clears all mask bits. A write to offset 0xF loads mask[3:0] from data[3:0].
- R9: A write to offset 0xD sets all mask bits and clears the command byte, the terminal-count flags and the toggle. It leaves the address and count registers unchanged.
- R10: A write to offset 0x8 loads the command byte. A read at offset 0x8 returns {req_pend[3:0], terminal_count[3:0]}.
- R11: A high `tc_set[i]` latches terminal-count flag i until a status read or a master clear clears it. A set arriving in the same cycle as the clear wins.
- R12: A write-back from the sequencer (`seq_we`) replaces the current address and count of channel `seq_ch` and leaves the base copies unchanged. If a host byte write hits the same register in the same cycle, the host byte wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data, valid the cycle after `io_rd` |
| seq_we | input | 1 | Sequencer write-back of current address and count |
| seq_ch | input | 2 | Channel of the write-back |
| seq_addr | input | 16 | Current address written back |
| seq_cnt | input | 16 | Current count written back |
| tc_set | input | 4 | Terminal-count pulses, one per channel |
| req_pend | input | 4 | Pending-request levels, shown in status |
| base_addr | output | 4x16 | Base address per channel |
| base_cnt | output | 4x16 | Base count per channel |
| cur_addr | output | 4x16 | Current address per channel |
| cur_cnt | output | 4x16 | Current count per channel |
| ch_mode | output | 4x6 | Mode field per channel |
| ch_mask | output | 4 | Mask bit per channel |
| cmd_reg | output | 8 | Command byte |

## Verification
The properties assume that `io_wr` and `io_rd` are never high together, and one of them checks this. They also assume that every access strobe lasts exactly one cycle, so a held strobe would flip the toggle once for each cycle it stays high. The stimulus drives single-cycle strobes from tasks and never overlaps a read with a write. It keeps sequencer write-backs clear of host writes to the same channel, except in one deliberate case that checks that the host byte wins.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int OFF_W      = 4;
  localparam logic [OFF_W-1:0] OFF_CMD    = 4'h8;
  localparam logic [OFF_W-1:0] OFF_MASK1  = 4'hA;
  localparam logic [OFF_W-1:0] OFF_MODE   = 4'hB;
  localparam logic [OFF_W-1:0] OFF_CLRPTR = 4'hC;
  localparam logic [OFF_W-1:0] OFF_MCLR   = 4'hD;
  localparam logic [OFF_W-1:0] OFF_UNMASK = 4'hE;
  localparam logic [OFF_W-1:0] OFF_MASKW  = 4'hF;
  localparam int MASK_BIT = 2;
endpackage

// File: rtl/dmareg_pair.sv
// One 16-bit register held as a base copy and a current copy.
module dmareg_pair #(
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        byte_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              seq_we,
  input  logic [REG_W-1:0]  seq_val,
  output logic [REG_W-1:0]  base,
  output logic [REG_W-1:0]  cur
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base <= '0;
      cur  <= '0;
    end else begin
      if (seq_we) cur <= seq_val;
      for (int b = 0; b < 2; b++) begin
        if (byte_we[b]) begin
          base[b*DATA_W +: DATA_W] <= wdata;
          cur[b*DATA_W +: DATA_W]  <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/dmareg_ctrl.sv
// Mask, mode, command, terminal-count flags and the shared byte toggle.
module dmareg_ctrl
  import dmareg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int MODE_W = DATA_W - 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic                          rd,
  input  logic [OFF_W-1:0]              addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic                          chan_acc,
  input  logic [NUM_CH-1:0]             tc_set,
  output logic [NUM_CH-1:0]             mask,
  output logic [NUM_CH-1:0][MODE_W-1:0] mode,
  output logic [DATA_W-1:0]             cmd,
  output logic [NUM_CH-1:0]             tc,
  output logic                          byte_hi
);
  logic mclr, stat_rd;
  logic [CH_W-1:0] wch;

  assign mclr    = wr && (addr == OFF_MCLR);
  assign stat_rd = rd && (addr == OFF_CMD);
  assign wch     = wdata[CH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '1;
      mode <= '0;
      cmd  <= '0;
    end else if (wr) begin
      case (addr)
        OFF_CMD:    cmd <= wdata;
        OFF_MASK1:  mask[wch] <= wdata[MASK_BIT];
        OFF_MODE:   mode[wch] <= wdata[DATA_W-1:2];
        OFF_MCLR: begin
          mask <= '1;
          cmd  <= '0;
        end
        OFF_UNMASK: mask <= '0;
        OFF_MASKW:  mask <= wdata[NUM_CH-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tc <= '0;
    else     tc <= ((mclr || stat_rd) ? '0 : tc) | tc_set;
  end

  always_ff @(posedge clk) begin
    if (rst)                                     byte_hi <= 1'b0;
    else if (mclr || (wr && addr == OFF_CLRPTR)) byte_hi <= 1'b0;
    else if (chan_acc)                           byte_hi <= ~byte_hi;
  end
endmodule

// File: rtl/dma_host_regs.sv
module dma_host_regs
  import dmareg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int REG_W  = 2 * DATA_W,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int MODE_W = DATA_W - 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [OFF_W-1:0]              io_addr,
  input  logic [DATA_W-1:0]             io_wdata,
  input  logic                          io_wr,
  input  logic                          io_rd,
  output logic [DATA_W-1:0]             io_rdata,
  input  logic                          seq_we,
  input  logic [CH_W-1:0]               seq_ch,
  input  logic [REG_W-1:0]              seq_addr,
  input  logic [REG_W-1:0]              seq_cnt,
  input  logic [NUM_CH-1:0]             tc_set,
  input  logic [NUM_CH-1:0]             req_pend,
  output logic [NUM_CH-1:0][REG_W-1:0]  base_addr,
  output logic [NUM_CH-1:0][REG_W-1:0]  base_cnt,
  output logic [NUM_CH-1:0][REG_W-1:0]  cur_addr,
  output logic [NUM_CH-1:0][REG_W-1:0]  cur_cnt,
  output logic [NUM_CH-1:0][MODE_W-1:0] ch_mode,
  output logic [NUM_CH-1:0]             ch_mask,
  output logic [DATA_W-1:0]             cmd_reg
);
  localparam int CHAN_SPAN = 2 * NUM_CH;

  logic              in_chan, chan_acc, byte_hi;
  logic [CH_W-1:0]   acc_ch;
  logic              acc_cnt;
  logic [NUM_CH-1:0] tc_q;
  logic [1:0]        lane_we;
  logic [REG_W-1:0]  rd_sel;

  assign in_chan  = (int'(io_addr) < CHAN_SPAN);
  assign chan_acc = (io_wr || io_rd) && in_chan;
  assign acc_ch   = io_addr[CH_W:1];
  assign acc_cnt  = io_addr[0];
  assign lane_we  = byte_hi ? 2'b10 : 2'b01;

  dmareg_ctrl #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr       (io_wr),
    .rd       (io_rd),
    .addr     (io_addr),
    .wdata    (io_wdata),
    .chan_acc (chan_acc),
    .tc_set   (tc_set),
    .mask     (ch_mask),
    .mode     (ch_mode),
    .cmd      (cmd_reg),
    .tc       (tc_q),
    .byte_hi  (byte_hi)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit, sq;
    assign hit = io_wr && in_chan && (acc_ch == CH_W'(g));
    assign sq  = seq_we && (seq_ch == CH_W'(g));

    dmareg_pair #(.DATA_W(DATA_W)) u_addr (
      .clk     (clk),
      .rst     (rst),
      .byte_we ((hit && !acc_cnt) ? lane_we : 2'b00),
      .wdata   (io_wdata),
      .seq_we  (sq),
      .seq_val (seq_addr),
      .base    (base_addr[g]),
      .cur     (cur_addr[g])
    );

    dmareg_pair #(.DATA_W(DATA_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .byte_we ((hit && acc_cnt) ? lane_we : 2'b00),
      .wdata   (io_wdata),
      .seq_we  (sq),
      .seq_val (seq_cnt),
      .base    (base_cnt[g]),
      .cur     (cur_cnt[g])
    );
  end

  assign rd_sel = acc_cnt ? cur_cnt[acc_ch] : cur_addr[acc_ch];

  always_ff @(posedge clk) begin
    if (rst || !io_rd)          io_rdata <= '0;
    else if (in_chan)           io_rdata <= byte_hi ? rd_sel[REG_W-1:DATA_W] : rd_sel[DATA_W-1:0];
    else if (io_addr == OFF_CMD) io_rdata <= DATA_W'({req_pend, tc_q});
    else                        io_rdata <= '0;
  end
endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk
  import dmareg_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input logic                         clk,
  input logic                         rst,
  input logic [OFF_W-1:0]             io_addr,
  input logic [DATA_W-1:0]            io_wdata,
  input logic                         io_wr,
  input logic                         io_rd,
  input logic                         seq_we,
  input logic [NUM_CH-1:0]            tc_set,
  input logic [NUM_CH-1:0]            ch_mask,
  input logic [DATA_W-1:0]            cmd_reg,
  input logic [NUM_CH-1:0][REG_W-1:0] base_addr,
  input logic [NUM_CH-1:0][REG_W-1:0] base_cnt,
  input logic [NUM_CH-1:0]            tc_q,
  input logic                         byte_hi
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  assert_reset_mask_R1: assert property (@(posedge clk)
    (rst_q === 1'b1 && !rst) |-> (ch_mask == '1 && !byte_hi && cmd_reg == '0));

  assert_excl_access_R3: assert property (@(posedge clk) disable iff (rst)
    !(io_wr && io_rd));

  assert_ptr_toggle_R3: assert property (@(posedge clk) disable iff (rst)
    ((io_wr || io_rd) && int'(io_addr) < 2 * NUM_CH) |=> (byte_hi != $past(byte_hi)));

  assert_ptr_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == OFF_CLRPTR) |=> !byte_hi);

  assert_mask_single_R6: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == OFF_MASK1) |=> (ch_mask[$past(io_wdata[1:0])] == $past(io_wdata[MASK_BIT])));

  assert_master_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == OFF_MCLR) |=>
      (ch_mask == '1 && cmd_reg == '0 && !byte_hi &&
       base_addr == $past(base_addr) && base_cnt == $past(base_cnt)));

  assert_tc_latch_R11: assert property (@(posedge clk) disable iff (rst)
    (tc_set != '0) |=> ((tc_q & $past(tc_set)) == $past(tc_set)));

  assert_seq_keeps_base_R12: assert property (@(posedge clk) disable iff (rst)
    (seq_we && !io_wr) |=> (base_addr == $past(base_addr) && base_cnt == $past(base_cnt)));
endmodule

bind dma_host_regs dmareg_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .io_addr   (io_addr),
  .io_wdata  (io_wdata),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .seq_we    (seq_we),
  .tc_set    (tc_set),
  .ch_mask   (ch_mask),
  .cmd_reg   (cmd_reg),
  .base_addr (base_addr),
  .base_cnt  (base_cnt),
  .tc_q      (tc_q),
  .byte_hi   (byte_hi)
);

// File: tb/dma_host_regs_test.sv
module dma_host_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        seq_we = 1'b0;
  logic [1:0]  seq_ch = '0;
  logic [15:0] seq_addr = '0, seq_cnt = '0;
  logic [3:0]  tc_set = '0, req_pend = '0;
  logic [3:0][15:0] base_addr, base_cnt, cur_addr, cur_cnt;
  logic [3:0][5:0]  ch_mode;
  logic [3:0]  ch_mask;
  logic [7:0]  cmd_reg;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_host_regs uut (.*);

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [15:0] m_ba[4], m_bc[4], m_ca[4], m_cc[4];
  logic [5:0]  m_mode[4];
  logic [3:0]  m_mask, m_tc;
  logic [7:0]  m_cmd, m_rd;
  logic        m_ff;

  always @(posedge clk) begin
    logic [15:0] v;
    logic [7:0]  nrd;
    int ch;
    bit clr;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        m_ba[i] = 0; m_bc[i] = 0; m_ca[i] = 0; m_cc[i] = 0; m_mode[i] = 0;
      end
      m_mask = 4'hF; m_tc = 0; m_cmd = 0; m_rd = 0; m_ff = 0;
    end else begin
      nrd = 0; clr = 0;
      ch = io_addr / 2;
      if (io_rd) begin
        if (io_addr < 8) begin
          v = io_addr[0] ? m_cc[ch] : m_ca[ch];
          nrd = m_ff ? v[15:8] : v[7:0];
          m_ff = !m_ff;
        end else if (io_addr == 8) begin
          nrd = {req_pend, m_tc};
          clr = 1;
        end
      end
      if (seq_we) begin
        m_ca[seq_ch] = seq_addr;
        m_cc[seq_ch] = seq_cnt;
      end
      if (io_wr) begin
        if (io_addr < 8) begin
          if (io_addr[0]) begin
            if (m_ff) begin m_bc[ch][15:8] = io_wdata; m_cc[ch][15:8] = io_wdata; end
            else      begin m_bc[ch][7:0]  = io_wdata; m_cc[ch][7:0]  = io_wdata; end
          end else begin
            if (m_ff) begin m_ba[ch][15:8] = io_wdata; m_ca[ch][15:8] = io_wdata; end
            else      begin m_ba[ch][7:0]  = io_wdata; m_ca[ch][7:0]  = io_wdata; end
          end
          m_ff = !m_ff;
        end else case (io_addr)
          4'h8: m_cmd = io_wdata;
          4'hA: m_mask[io_wdata[1:0]] = io_wdata[2];
          4'hB: m_mode[io_wdata[1:0]] = io_wdata[7:2];
          4'hC: m_ff = 0;
          4'hD: begin m_mask = 4'hF; m_cmd = 0; m_ff = 0; clr = 1; end
          4'hE: m_mask = 0;
          4'hF: m_mask = io_wdata[3:0];
          default: ;
        endcase
      end
      m_tc = (clr ? 4'h0 : m_tc) | tc_set;
      m_rd = nrd;
    end
  end

  // Compare every clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      chk("R5", "io_rdata", io_rdata, m_rd);
      chk("R6", "ch_mask", ch_mask, m_mask);
      chk("R10", "cmd_reg", cmd_reg, m_cmd);
      for (int i = 0; i < 4; i++) begin
        chk("R2", "base_addr", base_addr[i], m_ba[i]);
        chk("R2", "base_cnt", base_cnt[i], m_bc[i]);
        chk("R12", "cur_addr", cur_addr[i], m_ca[i]);
        chk("R12", "cur_cnt", cur_cnt[i], m_cc[i]);
        chk("R7", "ch_mode", ch_mode[i], m_mode[i]);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1;
    @(negedge clk); io_rd = 0; d = io_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1", "mask after reset", ch_mask, 4'hF);
    chk("R1", "rdata after reset", io_rdata, 8'h00);
    chk("R1", "addr after reset", base_addr[0], 16'h0);

    // R2 / R5: channel 1 address, low then high
    wr(4'h2, 8'h34); wr(4'h2, 8'h12);
    chk("R2", "ch1 base addr", base_addr[1], 16'h1234);
    rd(4'h2, d); chk("R5", "ch1 addr lo", d, 8'h34);
    rd(4'h2, d); chk("R5", "ch1 addr hi", d, 8'h12);

    // R3: toggle is shared across channels
    wr(4'h0, 8'hAA); wr(4'h5, 8'h77);
    chk("R3", "ch2 count hi byte", base_cnt[2], 16'h7700);
    chk("R3", "ch0 addr lo byte", base_addr[0], 16'h00AA);

    // R4: clear-pointer returns to low byte
    wr(4'h3, 8'h0F); wr(4'hC, 8'h00); wr(4'h3, 8'hF0);
    chk("R4", "ch1 count after clear", base_cnt[1], 16'h00F0);
    wr(4'hC, 8'h00);

    // R6 single masks
    wr(4'hA, 8'h01); wr(4'hA, 8'h06);
    chk("R6", "mask after single writes", ch_mask, 4'b1101);
    // R8 clear and write all
    wr(4'hE, 8'h00); chk("R8", "mask cleared", ch_mask, 4'h0);
    wr(4'hF, 8'h05); chk("R8", "mask all write", ch_mask, 4'h5);

    // R7 modes
    wr(4'hB, 8'h47); wr(4'hB, 8'h48); wr(4'hB, 8'hC1);
    chk("R7", "ch3 mode", ch_mode[3], 6'h11);
    chk("R7", "ch0 mode", ch_mode[0], 6'h12);
    chk("R7", "ch1 mode", ch_mode[1], 6'h30);

    // R12 sequencer write-back
    @(negedge clk); seq_we = 1; seq_ch = 1; seq_addr = 16'h4000; seq_cnt = 16'h0010;
    @(negedge clk); seq_we = 0;
    chk("R12", "ch1 cur addr", cur_addr[1], 16'h4000);
    chk("R12", "ch1 base addr kept", base_addr[1], 16'h1234);
    rd(4'h3, d); chk("R5", "ch1 cur count lo", d, 8'h10);
    wr(4'hC, 8'h00);
    // R12 host byte wins over same-cycle write-back
    @(negedge clk); seq_we = 1; seq_ch = 2; seq_addr = 16'hBEEF; seq_cnt = 16'h1111;
    io_addr = 4'h4; io_wdata = 8'h55; io_wr = 1;
    @(negedge clk); seq_we = 0; io_wr = 0;
    chk("R12", "host byte wins", cur_addr[2], 16'hBE55);
    wr(4'hC, 8'h00);

    // R10 / R11 status and command
    wr(4'h8, 8'h5A); chk("R10", "cmd", cmd_reg, 8'h5A);
    req_pend = 4'b1001;
    @(negedge clk); tc_set = 4'b0100;
    @(negedge clk); tc_set = 0;
    rd(4'h8, d); chk("R11", "status with tc", d, 8'h94);
    rd(4'h8, d); chk("R11", "status after clear", d, 8'h90);
    // set wins over clear in the same cycle
    @(negedge clk); io_addr = 4'h8; io_rd = 1; tc_set = 4'b0001;
    @(negedge clk); io_rd = 0; tc_set = 0;
    rd(4'h8, d); chk("R11", "set beats clear", d, 8'h91);

    // R9 master clear
    wr(4'h0, 8'h01);
    wr(4'hD, 8'h00);
    chk("R9", "mask set", ch_mask, 4'hF);
    chk("R9", "cmd cleared", cmd_reg, 8'h00);
    chk("R9", "addr kept", base_addr[1], 16'h1234);
    wr(4'h1, 8'h99); chk("R9", "toggle low after clear", base_cnt[0][7:0], 8'h99);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule